// File: doc/BRIEF.md
# Host Interrupt Cause Controller with Coalescing Delay

This block collects interrupt causes for a device register file and drives one level-sensitive interrupt line to the host. Hardware event pulses set bits in a main cause register and in a separate DMA-engine cause register. The host clears a bit by writing a one to it. An enable mask selects which main cause bits may raise the line. The DMA causes appear in the main cause view as three summary bits: receive, transmit and hardware error.

The line can be delayed by a programmable coalescing time. This time is counted in 32-microsecond ticks, and a parameter sets the clock cycles per tick. The delay lets several events share one host interrupt. A high-priority receive event in the DMA cause register skips the delay. A second byte in the control register sets up a periodic receive interrupt, which sets its own main cause bit at a programmable interval.

The host reaches the four registers through a plain 32-bit write port and a combinational read port. The offsets are: 0x0 for the main cause, 0x4 for the enable mask, 0x8 for the DMA cause, and 0xC for the control register. In the control register, bits [7:0] hold the coalescing delay and bits [15:8] hold the periodic interval.

Top module: `host_irq_coalescer`

## Requirements
- R1: A pulse on a latching bit of `hw_evt` sets that main cause bit. The latching bits are 0, 1, 3, 6, 7, 25 and 26. Writing 1 to offset 0x0 clears the bits written as 1. Bits written as 0 keep their value.
- R2: An unmasked pending cause is a main cause bit that is set while the same bit of the mask register (offset 0x4) is 1. The interrupt line is high only when at least one unmasked cause is pending.
- R3: After reset, the control register reads 0x00000040 (coalescing delay 64 ticks, periodic off). The cause registers and the mask read 0, and the interrupt line is low.
- R4: With a coalescing delay of 0, the line goes high in the same cycle that an unmasked cause becomes pending.
- R5: With a coalescing delay D > 0, the line goes high exactly D × TICK_CYCLES clock cycles after the first unmasked cause was latched, and not before.
- R6: The line stays high while any unmasked cause is pending. It falls once all of them are cleared, and the delay timer then restarts from zero for the next cause.
- R7: DMA cause bits (offset 0x8) latch from `dma_evt` at positions 0, 1, 16, 17, 30 and 31, and clear by writing 1. In the main cause view, bit 31 is the OR of DMA bits 16, 17 and 30; bit 27 is the OR of DMA bits 0 and 1; bit 29 mirrors DMA bit 31. Writing offset 0x0 does not clear these summary bits.
- R8: DMA bit 30 (high-priority receive) raises the line at once, with no coalescing delay, when mask bit 31 is set.
- R9: If control bits [15:8] hold a nonzero value P, main cause bit 28 is set every P × TICK_CYCLES cycles, counted from the write. A value of 0 stops it.
- R10: Pulses on `hw_evt` at any position other than those in R1 have no effect. This includes 27, 28, 29 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| hw_evt | input | 32 | Main cause event pulses |
| dma_evt | input | 32 | DMA cause event pulses |
| irq_o | output | 1 | Level interrupt line to the host |

## Verification
The hardest cases to reach from the ports are the exact edge where the coalescing delay expires and the restart of the timer after a clear. The bench uses a short tick and a delay of 3. It samples the line one cycle before and at the predicted expiry, then clears the cause, raises it again, and checks that the full delay is counted once more. For the periodic cause, the bench counts cycles from the control write and reads bit 28 on both sides of the first interval.

// File: rtl/hirq_pkg.sv
// Shared constants for the host interrupt coalescer: register offsets,
// cause bit positions and reset values.
package hirq_pkg;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned BYTE_W       = 8;

    // Register byte offsets
    localparam logic [7:0] OFS_CAUSE     = 8'h00;
    localparam logic [7:0] OFS_MASK      = 8'h04;
    localparam logic [7:0] OFS_DMA       = 8'h08;
    localparam logic [7:0] OFS_CTL       = 8'h0C;

    // Main cause summary positions (driven from the DMA register)
    localparam int unsigned B_SUM_RX     = 31;
    localparam int unsigned B_SUM_ERR    = 29;
    localparam int unsigned B_PERIODIC   = 28;
    localparam int unsigned B_SUM_TX     = 27;

    // DMA cause positions
    localparam int unsigned D_ERR        = 31;
    localparam int unsigned D_HIPRI      = 30;
    localparam int unsigned D_RX1        = 17;
    localparam int unsigned D_RX0        = 16;
    localparam int unsigned D_TX1        = 1;
    localparam int unsigned D_TX0        = 0;

    // Bits of hw_evt that latch: 0,1,3,6,7,25,26
    localparam logic [DATA_W-1:0] HW_LATCH_MASK  = 32'h0600_00CB;
    // Bits of dma_evt that latch: 0,1,16,17,30,31
    localparam logic [DATA_W-1:0] DMA_LATCH_MASK = 32'hC003_0003;

    localparam logic [BYTE_W-1:0] DLY_RESET = 8'h40;
    localparam logic [BYTE_W-1:0] PER_RESET = 8'h00;

    // Control register content
    typedef struct packed {
        logic [BYTE_W-1:0] per;
        logic [BYTE_W-1:0] dly;
    } ctl_t;
endpackage

// File: rtl/hirq_regs.sv
// Register file of the interrupt coalescer.
// Holds the main cause, mask, DMA cause and control registers, performs
// write-one-to-clear and event latching, and builds the main cause view
// with the DMA summary bits. Assumes event pulses are synchronous to clk.
// A set and a clear of the same bit in one cycle leaves the bit set.
module hirq_regs
    import hirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_evt,
    input  logic [DATA_W-1:0] dma_evt,
    input  logic              per_pulse,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] cause_view,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] dma_q,
    output ctl_t              ctl_q
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_DMA   = ADDR_W'(OFS_DMA);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFS_CTL);

    logic                wr_cause, wr_mask, wr_dma, wr_ctl;
    logic [DATA_W-1:0]   cause_set, cause_clr, dma_set, dma_clr;
    logic [DATA_W-1:0]   summary;

    // Decode write strobes per register
    always_comb begin
        wr_cause = wr_en && (wr_addr == A_CAUSE);
        wr_mask  = wr_en && (wr_addr == A_MASK);
        wr_dma   = wr_en && (wr_addr == A_DMA);
        wr_ctl   = wr_en && (wr_addr == A_CTL);
    end

    // Form set and clear vectors for both cause registers
    always_comb begin
        cause_set = hw_evt & HW_LATCH_MASK;
        cause_set[B_PERIODIC] = per_pulse;
        cause_clr = wr_cause ? wr_data : '0;
        dma_set   = dma_evt & DMA_LATCH_MASK;
        dma_clr   = wr_dma ? wr_data : '0;
    end

    // Main cause latch: set by events, cleared by host write-one
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~cause_clr) | cause_set;
    end

    // DMA cause latch: set by DMA events, cleared by host write-one
    always_ff @(posedge clk) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= (dma_q & ~dma_clr) | dma_set;
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_data;
    end

    // Control register: coalescing delay and periodic interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.dly <= DLY_RESET;
            ctl_q.per <= PER_RESET;
        end else if (wr_ctl) begin
            ctl_q <= wr_data[2*BYTE_W-1:0];
        end
    end

    // Summarise DMA causes into main cause positions
    always_comb begin
        summary = '0;
        summary[B_SUM_RX]  = dma_q[D_RX0] | dma_q[D_RX1] | dma_q[D_HIPRI];
        summary[B_SUM_TX]  = dma_q[D_TX0] | dma_q[D_TX1];
        summary[B_SUM_ERR] = dma_q[D_ERR];
        cause_view = cause_q | summary;
    end

    // Read multiplexer
    always_comb begin
        unique case (rd_addr)
            A_CAUSE: rd_data = cause_view;
            A_MASK:  rd_data = mask_q;
            A_DMA:   rd_data = dma_q;
            A_CTL:   rd_data = {{(DATA_W-2*BYTE_W){1'b0}}, ctl_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hirq_tick_timer.sv
// Tick-based interval timer shared by the coalescing and periodic paths.
// While run is high it counts clock cycles in ticks of TICK_CYCLES and
// asserts last for one cycle when the limit in ticks is reached.
// With WRAP=1 it starts over after last; with WRAP=0 it holds done high
// until run drops. A low run or a limit of zero clears all state.
module hirq_tick_timer #(
    parameter int unsigned TICK_CYCLES = 1000,
    parameter int unsigned LIMIT_W     = 8,
    parameter bit          WRAP        = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [LIMIT_W-1:0] limit,
    output logic               last,
    output logic               done
);
    localparam int unsigned CYC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(TICK_CYCLES - 1);

    logic [CYC_W-1:0]   cyc_q;
    logic [LIMIT_W-1:0] tk_q;
    logic               done_q;
    logic               active;

    // Timer is active when enabled, limit nonzero and not already done
    always_comb begin
        active = run && (limit != '0) && !done_q;
        last   = active && (cyc_q == CYC_LAST) && (tk_q == limit - LIMIT_W'(1));
        done   = done_q;
    end

    // Cycle and tick counters with expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n || !run || (limit == '0)) begin
            cyc_q  <= '0;
            tk_q   <= '0;
            done_q <= 1'b0;
        end else if (active) begin
            if (cyc_q == CYC_LAST) begin
                cyc_q <= '0;
                if (last) begin
                    tk_q   <= '0;
                    done_q <= !WRAP;
                end else begin
                    tk_q <= tk_q + LIMIT_W'(1);
                end
            end else begin
                cyc_q <= cyc_q + CYC_W'(1);
            end
        end
    end
endmodule

// File: rtl/hirq_coalesce.sv
// Coalescing stage: decides when the host line rises.
// The delay timer runs while an unmasked cause is pending and clears when
// none is pending. The line is the pending flag qualified by delay expiry,
// a zero delay, or the high-priority receive bypass.
module hirq_coalesce
    import hirq_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic              hipri,
    input  logic [BYTE_W-1:0] dly,
    output logic              irq
);
    logic expired;
    logic unused_last;

    hirq_tick_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .LIMIT_W     (BYTE_W),
        .WRAP        (1'b0)
    ) u_dly_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pend),
        .limit (dly),
        .last  (unused_last),
        .done  (expired)
    );

    // Gate the pending flag with the delay outcome or bypass
    always_comb begin
        irq = (pend && (expired || (dly == '0))) || hipri;
    end
endmodule

// File: rtl/hirq_periodic.sv
// Periodic receive interrupt generator.
// Produces a one-cycle pulse every interval ticks while interval is
// nonzero; the count starts over whenever interval becomes zero.
module hirq_periodic
    import hirq_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] interval,
    output logic              pulse
);
    logic unused_done;

    hirq_tick_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .LIMIT_W     (BYTE_W),
        .WRAP        (1'b1)
    ) u_per_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (1'b1),
        .limit (interval),
        .last  (pulse),
        .done  (unused_done)
    );
endmodule

// File: rtl/host_irq_coalescer.sv
// Top of the host interrupt coalescer.
// Connects the register file, the periodic generator and the coalescing
// stage. Assumes a single clock domain and synchronous event pulses.
module host_irq_coalescer
    import hirq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [31:0]       hw_evt,
    input  logic [31:0]       dma_evt,
    output logic              irq_o
);
    logic [DATA_W-1:0] cause_q, cause_view, mask_q, dma_q;
    ctl_t              ctl_q;
    logic              per_pulse;
    logic              pend_w, hipri_w;

    hirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .hw_evt     (hw_evt),
        .dma_evt    (dma_evt),
        .per_pulse  (per_pulse),
        .cause_q    (cause_q),
        .cause_view (cause_view),
        .mask_q     (mask_q),
        .dma_q      (dma_q),
        .ctl_q      (ctl_q)
    );

    hirq_periodic #(.TICK_CYCLES(TICK_CYCLES)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (ctl_q.per),
        .pulse    (per_pulse)
    );

    // Pending unmasked causes and high-priority bypass condition
    always_comb begin
        pend_w  = |(cause_view & mask_q);
        hipri_w = dma_q[D_HIPRI] && mask_q[B_SUM_RX];
    end

    hirq_coalesce #(.TICK_CYCLES(TICK_CYCLES)) u_coal (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_w),
        .hipri (hipri_w),
        .dly   (ctl_q.dly),
        .irq   (irq_o)
    );
endmodule

// File: rtl/host_irq_coalescer_chk.sv
// Assertion checker for host_irq_coalescer, attached by bind.
// Observes ports and the internal pending, bypass and cause state.
module host_irq_coalescer_chk
    import hirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_o,
    input logic              pend,
    input logic              hipri,
    input logic [BYTE_W-1:0] dly,
    input logic [DATA_W-1:0] cause_q,
    input logic [DATA_W-1:0] dma_q
);
    logic wr_cause, wr_dma;

    // Write strobes seen from the port side
    always_comb begin
        wr_cause = wr_en && (wr_addr == ADDR_W'(OFS_CAUSE));
        wr_dma   = wr_en && (wr_addr == ADDR_W'(OFS_DMA));
    end

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_cause) |-> ((cause_q & $past(cause_q)) == $past(cause_q))); // R1
    AST_LINE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend); // R2
    AST_ZERO_DELAY_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (dly == '0)) |-> irq_o); // R4
    AST_NO_EARLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ((dly == '0) || hipri || $past(pend))); // R5
    AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_dma) |-> ((dma_q & $past(dma_q)) == $past(dma_q))); // R7
    AST_HIPRI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        hipri |-> irq_o); // R8
endmodule

bind host_irq_coalescer host_irq_coalescer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq_o   (irq_o),
    .pend    (pend_w),
    .hipri   (hipri_w),
    .dly     (ctl_q.dly),
    .cause_q (cause_q),
    .dma_q   (dma_q)
);

// File: tb/test_host_irq_coalescer.sv
// Scoreboard bench: driver tasks queue expected values, a monitor pops
// them and compares against the design outputs at mid-cycle.
module test_host_irq_coalescer;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned TICK       = 4;
    localparam int unsigned DLY        = 3;
    localparam int unsigned PER        = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic [31:0]       hw_evt = '0;
    logic [31:0]       dma_evt = '0;
    logic              irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_irq_coalescer #(.ADDR_W(ADDR_W), .TICK_CYCLES(TICK)) i_host_irq_coalescer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_evt(hw_evt), .dma_evt(dma_evt), .irq_o(irq_o)
    );

    // Monitor: pop expected items and compare with outputs
    initial begin
        forever begin
            exp_t it;
            logic [31:0] act;
            wait (exp_q.size() != 0);
            it  = exp_q.pop_front();
            act = it.is_irq ? {31'd0, irq_o} : rd_data;
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input string tag, input bit is_irq, input logic [31:0] exp);
        exp_t it;
        it.tag = tag; it.is_irq = is_irq; it.exp = exp;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic chk_reg(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        push(tag, 1'b0, exp);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        push(tag, 1'b1, {31'd0, exp});
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hw_pulse(input logic [31:0] v);
        @(negedge clk); hw_evt = v;
        @(negedge clk); hw_evt = '0;
    endtask

    task automatic dma_pulse(input logic [31:0] v);
        @(negedge clk); dma_evt = v;
        @(negedge clk); dma_evt = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Driver: stimulus sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk_reg(4'hC, 32'h0000_0040, "R3 ctl reset");
        chk_reg(4'h0, 32'h0, "R3 cause reset");
        chk_reg(4'h4, 32'h0, "R3 mask reset");
        chk_irq(1'b0, "R3 irq reset");

        // R1 latch and write-one-to-clear
        hw_pulse(32'h0000_0041);
        chk_reg(4'h0, 32'h0000_0041, "R1 latch");
        wr(4'h0, 32'h0000_0001);
        chk_reg(4'h0, 32'h0000_0040, "R1 w1c");
        wr(4'h0, 32'h0);
        chk_reg(4'h0, 32'h0000_0040, "R1 write zero keeps");
        wr(4'h0, 32'h0000_0040);
        chk_reg(4'h0, 32'h0, "R1 cleared");

        // R10 non-latching positions ignored
        hw_pulse(32'hB800_0004);
        chk_reg(4'h0, 32'h0, "R10 ignored bits");

        // R2 masking, R4 zero delay, R6 drop on clear
        wr(4'hC, 32'h0);
        hw_pulse(32'h0000_0002);
        chk_irq(1'b0, "R2 masked cause");
        wr(4'h4, 32'h0000_0002);
        chk_irq(1'b1, "R4 zero delay immediate");
        wr(4'h0, 32'h0000_0002);
        chk_irq(1'b0, "R6 line falls on clear");

        // R5 exact coalescing delay
        wr(4'hC, DLY);
        wr(4'h4, 32'h0000_0008);
        hw_pulse(32'h0000_0008);
        chk_irq(1'b0, "R5 not at latch");
        repeat (DLY*TICK-1) @(negedge clk);
        chk_irq(1'b0, "R5 one cycle before expiry");
        @(negedge clk);
        chk_irq(1'b1, "R5 at expiry");
        repeat (5) @(negedge clk);
        chk_irq(1'b1, "R6 holds while pending");
        // R6 restart of the timer
        wr(4'h0, 32'h0000_0008);
        chk_irq(1'b0, "R6 cleared");
        hw_pulse(32'h0000_0008);
        repeat (DLY*TICK-1) @(negedge clk);
        chk_irq(1'b0, "R6 restart not early");
        @(negedge clk);
        chk_irq(1'b1, "R6 restart full delay");
        wr(4'h0, 32'h0000_0008);
        wr(4'h4, 32'h0);

        // R7 DMA summary
        dma_pulse(32'h0001_0000);
        chk_reg(4'h8, 32'h0001_0000, "R7 dma latch");
        chk_reg(4'h0, 32'h8000_0000, "R7 rx summary");
        wr(4'h0, 32'h8000_0000);
        chk_reg(4'h0, 32'h8000_0000, "R7 summary not cleared via cause");
        dma_pulse(32'h8000_0002);
        chk_reg(4'h0, 32'hA800_0000, "R7 tx and err summary");
        wr(4'h8, 32'hFFFF_FFFF);
        chk_reg(4'h0, 32'h0, "R7 cleared via dma");

        // R8 high-priority bypass
        wr(4'h4, 32'h8000_0000);
        dma_pulse(32'h0002_0000);
        chk_irq(1'b0, "R8 normal rx delayed");
        wr(4'h8, 32'h0002_0000);
        dma_pulse(32'h4000_0000);
        chk_irq(1'b1, "R8 hipri immediate");
        wr(4'h8, 32'h4000_0000);
        chk_irq(1'b0, "R8 cleared");
        wr(4'h4, 32'h0);

        // R9 periodic cause
        wr(4'hC, (PER << 8) | DLY);
        repeat (PER*TICK-1) @(negedge clk);
        chk_reg(4'h0, 32'h0, "R9 before interval");
        @(negedge clk);
        chk_reg(4'h0, 32'h1000_0000, "R9 periodic set");
        wr(4'hC, DLY);
        wr(4'h0, 32'h1000_0000);
        repeat (20) @(negedge clk);
        chk_reg(4'h0, 32'h0, "R9 disabled");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule